// File: doc/BRIEF.md
# Register-Mapped GPIO Bank with Per-Line Interrupts

This block controls a bank of general-purpose pins through a small 32-bit register bus. The bus has an address, a write strobe, write data and read data. Reads are combinational from the current address. Software picks the direction of each line, and reads each input through a two-flop synchronizer. It changes output levels only through a write-one-to-set word and a write-one-to-clear word, so it never needs a read-modify-write of the output latch.

Each line can raise an interrupt. Software chooses level or edge sensitivity and the active polarity. An enable bit gates detection and a separate mask bit gates forwarding. Edge events latch in a pending word and are cleared by writing one to that bit. Level events follow the pin. The qualified pending bits are ORed, then registered, to drive one interrupt output.

A build parameter selects the sense of the direction bits. The pad buffers are modelled by separate output-value and output-enable vectors.

Top module: `gpio_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all direction, output, enable, type, polarity, mask and pending bits are 0 and `irq` is 0. `pad_oe` is then all 0 in the default variant and all 1 in the inverted variant.
- R2: A write to byte offset 0x0C sets every output bit whose data bit is 1, and a write to 0x10 clears every output bit whose data bit is 1. Data bits at 0 leave their lines unchanged. Offsets 0x0C and 0x10 both read back the output latch, and `pad_out` carries the latch.
- R3: The direction word is at offset 0x00. With `DIR_INVERT=0`, `pad_oe[i]` equals direction bit i. With `DIR_INVERT=1`, `pad_oe[i]` is its inverse.
- R4: Offset 0x04 reads `pad_in` after two register stages. A pin value present before clock edge k is readable after edge k+1.
- R5: The interrupt word offsets are: 0x14 enable, 0x18 type, 0x1C polarity, 0x24 mask. For each of them, and for direction, the value written reads back.
- R6: A line whose type bit is 1 (level) has its pending bit at 0x20 set while it is enabled and its synchronized pin equals its polarity bit. Otherwise that pending bit is 0. Writing 1 to the pending bit of a level line has no effect.
- R7: A line whose type bit is 0 (edge) latches its pending bit on a rising edge when polarity is 1, or on a falling edge when polarity is 0, provided it is enabled. The opposite edge leaves the bit set. Writing 1 to the bit at 0x20 clears it.
- R8: `irq` is the OR over lines of pending, enable and mask, taken one cycle late. A line with mask 0 shows pending without raising `irq`. A line with enable 0 does not set pending.
- R9: Data bits at and above `NUM_LINES` read as 0 at every offset and are ignored on writes. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the accessed word |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pad_in | input | NUM_LINES | Asynchronous pin levels |
| pad_out | output | NUM_LINES | Output latch driven to the pads |
| pad_oe | output | NUM_LINES | Pad driver enable, 1 = drive |
| irq | output | 1 | Combined registered interrupt |

## Verification
The assertions assume that `bus_we` is 0 during reset. They also assume that `pad_in` is sampled once per clock, so the edge detector compares adjacent synchronized samples. The stimulus changes pins and bus signals only on the falling clock edge. It releases reset with the write strobe low. It keeps a pin steady for several cycles after each change, so that every edge, level and clear is seen after the full synchronizer and pending-register latency before the next check.

// File: rtl/gpio_pkg.sv
// Package: shared byte offsets of the GPIO register words.
// Assumes every offset fits the bus address width used by the top.
package gpio_pkg;
    localparam logic [31:0] OFF_DIR   = 32'h00;
    localparam logic [31:0] OFF_IN    = 32'h04;
    localparam logic [31:0] OFF_SET   = 32'h0C;
    localparam logic [31:0] OFF_CLR   = 32'h10;
    localparam logic [31:0] OFF_IEN   = 32'h14;
    localparam logic [31:0] OFF_ITYPE = 32'h18;
    localparam logic [31:0] OFF_IPOL  = 32'h1C;
    localparam logic [31:0] OFF_PEND  = 32'h20;
    localparam logic [31:0] OFF_IMASK = 32'h24;
endpackage

// File: rtl/gpio_sync2.sv
// Module: two-stage synchronizer for the pin vector, plus one more stage
// holding the previous synchronized sample for edge detection.
// Assumes pins are asynchronous to clk; reset is synchronous, active low.
module gpio_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    // Capture the pins, resolve metastability, keep the previous sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign sync_o = sync_q;
    assign prev_o = prev_q;
endmodule

// File: rtl/gpio_irq.sv
// Module: per-line interrupt detection and the combined interrupt.
// Level lines track (enable AND pin==polarity); edge lines latch on the
// selected edge and clear on a write-one. Output is registered.
// Assumes sync_i/prev_i are adjacent synchronized samples.
module gpio_irq #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] prev_i,
    input  logic [W-1:0] ien_i,
    input  logic [W-1:0] itype_i,
    input  logic [W-1:0] ipol_i,
    input  logic [W-1:0] imask_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] pend_o,
    output logic         irq_o
);
    logic [W-1:0] pend_q;
    logic [W-1:0] level_on;
    logic [W-1:0] edge_on;
    logic         irq_q;

    for (genvar g = 0; g < W; g++) begin : g_line
        // Qualify the level and the selected edge of one line.
        always_comb begin
            level_on[g] = ien_i[g] & (sync_i[g] == ipol_i[g]);
            edge_on[g]  = ien_i[g] & (ipol_i[g] ? (sync_i[g] & ~prev_i[g])
                                                : (~sync_i[g] & prev_i[g]));
        end

        // Pending bit: follow the level, or latch the edge until cleared.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_q[g] <= 1'b0;
            else if (itype_i[g])
                pend_q[g] <= level_on[g];
            else
                pend_q[g] <= edge_on[g] | (pend_q[g] & ~clr_i[g]);
        end
    end

    // Register the OR of forwarded pending bits.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(pend_q & ien_i & imask_i);
    end

    assign pend_o = pend_q;
    assign irq_o  = irq_q;

    assert_level_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(itype_i & ien_i & ~(sync_i ^ ipol_i)) & ~pend_q) == '0));

    assert_edge_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(~itype_i & pend_q & ~clr_i) & ~pend_q) == '0));

    assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(|(pend_q & ien_i & imask_i)));

    assert_irq_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(|(pend_q & ien_i & imask_i))) |-> irq_q);
endmodule

// File: rtl/gpio_ctrl.sv
// Module: GPIO bank top. Holds the direction, output and interrupt
// configuration registers, decodes the bus and muxes read data.
// Assumes NUM_LINES < 32, one bus access per cycle, reads combinational.
module gpio_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_LINES  = 8,
    parameter bit DIR_INVERT = 1'b0,
    parameter int ADDR_W     = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] pad_in,
    output logic [NUM_LINES-1:0] pad_out,
    output logic [NUM_LINES-1:0] pad_oe,
    output logic                 irq
);
    localparam int N   = NUM_LINES;
    localparam int PAD = 32 - N;

    initial begin
        if (N < 1 || N > 31) $error("NUM_LINES must be 1..31");
    end

    logic [31:0]  addr_w;
    logic [N-1:0] wd;
    logic         unused_wdata_hi;
    logic [N-1:0] dir_q, out_q, ien_q, itype_q, ipol_q, imask_q;
    logic [N-1:0] sync_v, prev_v, pend_v, clr_v;
    logic         we_dir, we_set, we_clr, we_ien, we_itype, we_ipol, we_pend, we_imask;
    logic [N-1:0] rd_lane;

    assign addr_w          = 32'(bus_addr);
    assign wd              = bus_wdata[N-1:0];
    assign unused_wdata_hi = ^bus_wdata[31:N];

    // Decode write strobes for each register word.
    always_comb begin
        we_dir   = bus_we && (addr_w == OFF_DIR);
        we_set   = bus_we && (addr_w == OFF_SET);
        we_clr   = bus_we && (addr_w == OFF_CLR);
        we_ien   = bus_we && (addr_w == OFF_IEN);
        we_itype = bus_we && (addr_w == OFF_ITYPE);
        we_ipol  = bus_we && (addr_w == OFF_IPOL);
        we_pend  = bus_we && (addr_w == OFF_PEND);
        we_imask = bus_we && (addr_w == OFF_IMASK);
    end

    // Configuration and output latch updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= '0;
            out_q   <= '0;
            ien_q   <= '0;
            itype_q <= '0;
            ipol_q  <= '0;
            imask_q <= '0;
        end else begin
            if (we_dir)   dir_q   <= wd;
            if (we_set)   out_q   <= out_q | wd;
            if (we_clr)   out_q   <= out_q & ~wd;
            if (we_ien)   ien_q   <= wd;
            if (we_itype) itype_q <= wd;
            if (we_ipol)  ipol_q  <= wd;
            if (we_imask) imask_q <= wd;
        end
    end

    assign clr_v = we_pend ? wd : '0;

    gpio_sync2 #(.W(N)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_in),
        .sync_o  (sync_v),
        .prev_o  (prev_v)
    );

    gpio_irq #(.W(N)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_i  (sync_v),
        .prev_i  (prev_v),
        .ien_i   (ien_q),
        .itype_i (itype_q),
        .ipol_i  (ipol_q),
        .imask_i (imask_q),
        .clr_i   (clr_v),
        .pend_o  (pend_v),
        .irq_o   (irq)
    );

    // Select the read lane for the addressed word.
    always_comb begin
        case (addr_w)
            OFF_DIR:   rd_lane = dir_q;
            OFF_IN:    rd_lane = sync_v;
            OFF_SET:   rd_lane = out_q;
            OFF_CLR:   rd_lane = out_q;
            OFF_IEN:   rd_lane = ien_q;
            OFF_ITYPE: rd_lane = itype_q;
            OFF_IPOL:  rd_lane = ipol_q;
            OFF_PEND:  rd_lane = pend_v;
            OFF_IMASK: rd_lane = imask_q;
            default:   rd_lane = '0;
        endcase
    end

    assign bus_rdata = {{PAD{1'b0}}, rd_lane};

    // Pad drivers: direction sense chosen at build time.
    if (DIR_INVERT) begin : g_oe_inv
        assign pad_oe = ~dir_q;
    end else begin : g_oe_norm
        assign pad_oe = dir_q;
    end
    assign pad_out = out_q;

    assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(we_set)) |-> ((pad_out & $past(bus_wdata[N-1:0])) == $past(bus_wdata[N-1:0])));

    assert_clr_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(we_clr)) |-> ((pad_out & $past(bus_wdata[N-1:0])) == '0));

    assert_sync_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 1) && $past(rst_n, 2)) |-> (sync_v == $past(pad_in, 2)));

    assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:N] == '0);
endmodule

// File: tb/tb_gpio_ctrl.sv
module tb_gpio_ctrl;
    localparam int CLK_P = 10;
    localparam int N     = 8;
    localparam logic [31:0] LMASK = 32'h0000_00FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata, rdata_inv;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_out, pad_oe, pad_out_inv, pad_oe_inv;
    logic        irq, irq_inv;
    int          n_tests = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    gpio_ctrl #(.NUM_LINES(N), .DIR_INVERT(1'b0), .ADDR_W(6)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

    gpio_ctrl #(.NUM_LINES(N), .DIR_INVERT(1'b1), .ADDR_W(6)) dut_inv (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_inv), .pad_in(pad_in),
        .pad_out(pad_out_inv), .pad_oe(pad_oe_inv), .irq(irq_inv));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        bus_addr = a[5:0]; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        bus_addr = a[5:0];
        #1;
        d = rdata;
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
        end
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] o_exp;
        @(negedge clk); cyc(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        foreach (gpio_pkg::OFF_DIR[i]) begin end
        rd(32'h00, v); chk("R1 dir", v, 0);
        rd(32'h0C, v); chk("R1 out", v, 0);
        rd(32'h14, v); chk("R1 ien", v, 0);
        rd(32'h18, v); chk("R1 type", v, 0);
        rd(32'h1C, v); chk("R1 pol", v, 0);
        rd(32'h20, v); chk("R1 pend", v, 0);
        rd(32'h24, v); chk("R1 mask", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 oe default", {24'b0, pad_oe}, 0);
        chk("R1 oe inverted", {24'b0, pad_oe_inv}, 32'hFF);

        // R2 set/clear sweep across patterns
        o_exp = 0;
        for (int p = 0; p < 16; p++) begin
            logic [31:0] s, c;
            s = 32'hFFFF_FF00 | ((p * 37 + 5) & 32'hFF);
            c = 32'hFFFF_FF00 | ((p * 91 + 3) & 32'hFF);
            wr(32'h0C, s); o_exp = (o_exp | s) & LMASK;
            rd(32'h0C, v); chk("R2 set", v, o_exp);
            chk("R2 pad_out", {24'b0, pad_out}, o_exp);
            wr(32'h10, c); o_exp = o_exp & ~c & LMASK;
            rd(32'h10, v); chk("R2 clr", v, o_exp);
            chk("R2 pad_out", {24'b0, pad_out}, o_exp);
        end

        // R3 direction sense in both variants
        for (int p = 0; p < 256; p += 17) begin
            wr(32'h00, 32'hABCD_0000 | p);
            chk("R3 oe default", {24'b0, pad_oe}, p & 32'hFF);
            chk("R3 oe inverted", {24'b0, pad_oe_inv}, ~p & 32'hFF);
        end
        wr(32'h00, 0);

        // R4 input synchronizer: every pin pattern, readable two edges later
        for (int p = 0; p < 256; p++) begin
            pad_in = p[7:0];
            cyc(2);
            rd(32'h04, v); chk("R4 input", v, p);
        end
        pad_in = '0; cyc(3);

        // R5 / R9 readback and upper bits
        wr(32'h18, 32'hFFFF_FFFF); rd(32'h18, v); chk("R5 R9 type", v, 32'hFF);
        wr(32'h1C, 32'hFFFF_FFFF); rd(32'h1C, v); chk("R5 R9 pol", v, 32'hFF);
        wr(32'h24, 32'hFFFF_FFFF); rd(32'h24, v); chk("R5 R9 mask", v, 32'hFF);
        wr(32'h00, 32'hFFFF_FF5A); rd(32'h00, v); chk("R5 R9 dir", v, 32'h5A);
        wr(32'h14, 32'hFFFF_FF00); rd(32'h14, v); chk("R5 R9 ien", v, 0);
        wr(32'h14, 32'h0000_00C3); rd(32'h14, v); chk("R5 ien", v, 32'hC3);
        wr(32'h14, 0); wr(32'h00, 0);
        wr(32'h18, 0); wr(32'h1C, 0); wr(32'h24, 0);
        rd(32'h08, v); chk("R9 unmapped 08", v, 0);
        rd(32'h28, v); chk("R9 unmapped 28", v, 0);
        rd(32'h3C, v); chk("R9 unmapped 3C", v, 0);

        // R6 / R7 / R8 interrupt sweep: every line, every type/polarity
        for (int i = 0; i < N; i++) begin
            for (int m = 0; m < 4; m++) begin
                logic lvl, pol;
                logic [31:0] b;
                lvl = m[1]; pol = m[0]; b = 32'h1 << i;
                wr(32'h14, 0); wr(32'h20, 32'hFF);
                wr(32'h18, lvl ? b : 0); wr(32'h1C, pol ? b : 0);
                pad_in = '0; pad_in[i] = ~pol; cyc(4);
                wr(32'h20, 32'hFF);
                wr(32'h24, b); wr(32'h14, b); cyc(3);
                rd(32'h20, v); chk(lvl ? "R6 idle" : "R7 idle", v, 0);
                chk("R8 idle irq", {31'b0, irq}, 0);
                pad_in[i] = pol; cyc(4);
                rd(32'h20, v); chk(lvl ? "R6 active" : "R7 edge", v, b);
                chk("R8 irq on", {31'b0, irq}, 1);
                wr(32'h20, b); cyc(2);
                rd(32'h20, v); chk(lvl ? "R6 w1c ignored" : "R7 w1c", v, lvl ? b : 0);
                chk("R8 irq after w1c", {31'b0, irq}, lvl ? 1 : 0);
                if (!lvl) begin
                    pad_in[i] = ~pol; cyc(4);
                    pad_in[i] = pol; cyc(4);
                end
                pad_in[i] = ~pol; cyc(4);
                rd(32'h20, v); chk(lvl ? "R6 released" : "R7 opposite edge holds", v, lvl ? 0 : b);
                chk("R8 irq follows", {31'b0, irq}, lvl ? 0 : 1);
            end
        end

        // R8 mask blocks forwarding, enable blocks detection
        wr(32'h14, 0); wr(32'h20, 32'hFF); pad_in = '0; cyc(3);
        wr(32'h18, 0); wr(32'h1C, 32'h0F); wr(32'h24, 0); wr(32'h14, 32'h0F);
        pad_in = 8'h0F; cyc(4);
        rd(32'h20, v); chk("R8 masked pending", v, 32'h0F);
        chk("R8 masked irq", {31'b0, irq}, 0);
        wr(32'h24, 32'h04); cyc(2);
        chk("R8 unmask irq", {31'b0, irq}, 1);
        wr(32'h20, 32'hFF); wr(32'h14, 0); pad_in = 8'h00; cyc(2);
        wr(32'h1C, 32'hF0); wr(32'h24, 32'hFF); pad_in = 8'hF0; cyc(4);
        rd(32'h20, v); chk("R8 disabled no pending", v, 0);
        chk("R8 disabled irq", {31'b0, irq}, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule